// File: doc/BRIEF.md
# Synaptic Delay Ring Accumulator

This block holds, for every neuron of a population, a ring of sixteen signed 16-bit input slots that serves as a delay line for synaptic current. A stream of 32-bit synaptic words arrives on a valid/ready port. Each word names a target neuron, a signed weight and a delay in milliseconds. The block adds the weight into that neuron's slot that lies the given number of slots ahead of a global time pointer.

A neuron updater uses a separate read port to fetch the current input of a neuron, which is the slot under the time pointer. The block returns that value and clears the slot to zero in the same operation, so the slot is empty when the ring comes round to it again. A 1 ms tick input advances the time pointer by one slot.

All slots sit in one memory that can be built from block RAM. Accumulations to the same slot on consecutive cycles are forwarded inside the block, so every weight is counted.

Top module: `syn_delay_ring`

## Requirements
- R1: A synaptic word is decoded as follows: delay = bits 31:28, target neuron index = bits 26:16, signed weight = bits 15:0. Bit 27 has no effect on the result.
- R2: An accepted word adds its weight to slot (time_ptr + delay) mod 16 of the target neuron. The addition wraps in 16-bit two's complement.
- R3: When rd_req is high in a cycle, rd_valid is high two clock edges later and rd_current then holds slot time_ptr of neuron rd_neuron. rd_valid is low on the edge in between.
- R4: time_ptr is 0 after reset and steps by one on each edge where tick is high, wrapping from 15 to 0. It holds its value otherwise. A word or read issued in the same cycle as tick uses the pointer value from before the step.
- R5: A read clears the slot it returns, so a second read of the same slot returns zero unless new weights have been added to it.
- R6: A word whose index is not below NEURONS changes no slot. bad_index is high for the one cycle after that word is accepted and low after any other operation.
- R7: A read has priority over a word. word_ready is low while rd_req is high, and a word held valid across the read is accepted in the next cycle.
- R8: Updates to the same slot on back-to-back cycles are all accumulated. This covers a word after a word, a read right after words, and a word right after a read.
- R9: After reset rd_valid and bad_index are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | 1 ms time step; advances the time pointer |
| word_valid | input | 1 | A synaptic word is present |
| word_ready | output | 1 | The word is taken on this edge (low during a read request) |
| word_data | input | 32 | Synaptic word: delay, reserved bit, neuron index, weight |
| rd_req | input | 1 | Request the current input of rd_neuron |
| rd_neuron | input | IDX_W (11) | Neuron whose current slot is read and cleared |
| rd_valid | output | 1 | rd_current carries a read result |
| rd_current | output | 16 | Signed current value that was read |
| bad_index | output | 1 | The operation accepted on the previous edge had an out-of-range index |
| time_ptr | output | 4 | Current time slot |

## Verification
A word accepted on an edge has its sum written on the next edge. Its effect is therefore checked only through later reads, which the bench issues at least one edge after the word. A read result and rd_valid appear after two edges, and the bench samples them at the falling edge that follows the second edge, after confirming that rd_valid is still low one edge earlier. bad_index and the time pointer change one edge after their cause and are sampled at the next falling edge. A reference ring model in the bench sweeps every neuron through all sixteen slots. Dedicated sequences cover back-to-back forwarding, read priority and tick collisions at exact cycle spacings.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
  localparam int SLOT_W = 4;
  localparam int SLOTS  = 1 << SLOT_W;
  localparam int WGT_W  = 16;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic [SLOT_W-1:0]       delay;
    logic                    rsvd;
    logic [10:0]             index;
    logic signed [WGT_W-1:0] weight;
  } syn_word_t;
endpackage

// File: rtl/sdr_time_ptr.sv
module sdr_time_ptr #(
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [PTR_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (tick) ptr <= ptr + 1'b1;
  end

  a_r4_step: assert property (@(posedge clk) disable iff (rst)
    tick |=> ptr == PTR_W'($past(ptr) + 1'b1));
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(ptr));
endmodule

// File: rtl/sdr_slot_addr.sv
module sdr_slot_addr #(
  parameter int NEURONS = 32,
  parameter int IDX_W   = 11,
  parameter int SLOT_W  = 4,
  localparam int NB     = (NEURONS > 1) ? $clog2(NEURONS) : 1,
  localparam int ADDR_W = NB + SLOT_W
) (
  input  logic [IDX_W-1:0]  index,
  input  logic [SLOT_W-1:0] offset,
  input  logic [SLOT_W-1:0] ptr,
  output logic [ADDR_W-1:0] addr,
  output logic              bad
);
  logic [SLOT_W-1:0] slot;
  always_comb begin
    slot = ptr + offset;
    bad  = 32'(index) >= NEURONS;
    addr = {index[NB-1:0], slot};
  end
endmodule

// File: rtl/sdr_slot_ram.sv
module sdr_slot_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 9,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/syn_delay_ring.sv
module syn_delay_ring
  import sdr_pkg::*;
#(
  parameter int NEURONS = 32,
  parameter int IDX_W   = 11,
  localparam int NB     = (NEURONS > 1) ? $clog2(NEURONS) : 1,
  localparam int ADDR_W = NB + SLOT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              word_valid,
  output logic              word_ready,
  input  logic [WORD_W-1:0] word_data,
  input  logic              rd_req,
  input  logic [IDX_W-1:0]  rd_neuron,
  output logic              rd_valid,
  output logic [WGT_W-1:0]  rd_current,
  output logic              bad_index,
  output logic [SLOT_W-1:0] time_ptr
);
  syn_word_t w;
  logic rsvd_unused;
  assign w           = syn_word_t'(word_data);
  assign rsvd_unused = w.rsvd;

  sdr_time_ptr #(.PTR_W(SLOT_W)) u_ptr (
    .clk(clk), .rst(rst), .tick(tick), .ptr(time_ptr)
  );

  // Address of a word target and of a read target
  logic [ADDR_W-1:0] wa_addr, ra_addr;
  logic              wa_bad, ra_bad;

  sdr_slot_addr #(.NEURONS(NEURONS), .IDX_W(IDX_W), .SLOT_W(SLOT_W)) u_waddr (
    .index(IDX_W'(w.index)), .offset(w.delay), .ptr(time_ptr),
    .addr(wa_addr), .bad(wa_bad)
  );
  sdr_slot_addr #(.NEURONS(NEURONS), .IDX_W(IDX_W), .SLOT_W(SLOT_W)) u_raddr (
    .index(rd_neuron), .offset('0), .ptr(time_ptr),
    .addr(ra_addr), .bad(ra_bad)
  );

  // Stage 0: arbitration, reads win
  logic              op_go;
  logic [ADDR_W-1:0] s0_addr;
  logic              s0_bad;
  assign word_ready = ~rd_req;
  assign op_go      = rd_req | word_valid;
  assign s0_addr    = rd_req ? ra_addr : wa_addr;
  assign s0_bad     = rd_req ? ra_bad  : wa_bad;

  // Stage 1 registers
  logic              s1_valid, s1_rd, s1_bad;
  logic [ADDR_W-1:0] s1_addr;
  logic [WGT_W-1:0]  s1_wgt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_rd    <= 1'b0;
      s1_bad   <= 1'b0;
      s1_addr  <= '0;
      s1_wgt   <= '0;
    end else begin
      s1_valid <= op_go;
      s1_rd    <= rd_req;
      s1_bad   <= op_go & s0_bad;
      s1_addr  <= s0_addr;
      s1_wgt   <= w.weight;
    end
  end

  // Slot memory and one-deep write forwarding
  logic              wr_en;
  logic [WGT_W-1:0]  wr_data, ram_q, base;
  logic              fw_valid;
  logic [ADDR_W-1:0] fw_addr;
  logic [WGT_W-1:0]  fw_data;

  sdr_slot_ram #(.DATA_W(WGT_W), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .we(wr_en), .waddr(s1_addr), .wdata(wr_data),
    .raddr(s0_addr), .rdata(ram_q)
  );

  always_comb begin
    base    = (fw_valid && fw_addr == s1_addr) ? fw_data : ram_q;
    wr_en   = s1_valid & ~s1_bad;
    wr_data = s1_rd ? '0 : base + s1_wgt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fw_valid <= 1'b0;
      fw_addr  <= '0;
      fw_data  <= '0;
    end else begin
      fw_valid <= wr_en;
      fw_addr  <= s1_addr;
      fw_data  <= wr_data;
    end
  end

  // Registered read result
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid   <= 1'b0;
      rd_current <= '0;
    end else begin
      rd_valid <= s1_valid & s1_rd;
      if (s1_valid && s1_rd) rd_current <= s1_bad ? '0 : base;
    end
  end

  assign bad_index = s1_bad;

  a_r3_rd_latency: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> ##2 rd_valid);
  a_r6_flag_cause: assert property (@(posedge clk) disable iff (rst)
    bad_index |-> $past(word_valid || rd_req));
  a_r5_clear_written: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_rd && !s1_bad) |=> (fw_valid && fw_data == '0));
endmodule

// File: tb/sim_syn_delay_ring.sv
module sim_syn_delay_ring;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0, word_valid = 1'b0, rd_req = 1'b0;
  logic [31:0] word_data = '0;
  logic [10:0] rd_neuron = '0;
  logic        word_ready, rd_valid, bad_index;
  logic [15:0] rd_current;
  logic [3:0]  time_ptr;

  always #2 clk = ~clk;

  syn_delay_ring #(.NEURONS(N), .IDX_W(11)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .word_valid(word_valid),
    .word_ready(word_ready), .word_data(word_data), .rd_req(rd_req),
    .rd_neuron(rd_neuron), .rd_valid(rd_valid), .rd_current(rd_current),
    .bad_index(bad_index), .time_ptr(time_ptr)
  );

  logic [15:0] mdl [N][16];
  int mptr = 0;
  int total = 0, fails = 0;

  task automatic chk(input string tag, input logic ok, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int d, input int idx, input logic [15:0] wt,
                                     input logic b27);
    return {4'(d), b27, 11'(idx), wt};
  endfunction

  function automatic void madd(input int d, input int idx, input logic [15:0] wt);
    if (idx < N) mdl[idx][(mptr + d) % 16] = mdl[idx][(mptr + d) % 16] + wt;
  endfunction

  // One word, then check bad flag one edge later
  task automatic send(input int d, input int idx, input logic [15:0] wt, input logic b27);
    @(negedge clk); word_valid = 1'b1; word_data = mk(d, idx, wt, b27);
    @(posedge clk);
    @(negedge clk); word_valid = 1'b0;
    madd(d, idx, wt);
    chk("R6 bad_index", bad_index == (idx >= N), int'(bad_index), int'(idx >= N));
  endtask

  task automatic rd_raw(input int idx);
    @(negedge clk); rd_req = 1'b1; rd_neuron = 11'(idx);
    @(posedge clk);
    @(negedge clk); rd_req = 1'b0;
    @(posedge clk);
  endtask

  task automatic rd_chk(input int idx, input string tag);
    logic [15:0] e;
    e = mdl[idx][mptr];
    @(negedge clk); rd_req = 1'b1; rd_neuron = 11'(idx);
    @(posedge clk);
    @(negedge clk); rd_req = 1'b0;
    chk("R3 rd_valid early", rd_valid == 1'b0, int'(rd_valid), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R3 rd_valid", rd_valid == 1'b1, int'(rd_valid), 1);
    chk(tag, rd_current == e, int'(rd_current), int'(e));
    mdl[idx][mptr] = '0;
  endtask

  task automatic tick1();
    @(negedge clk); tick = 1'b1;
    @(posedge clk);
    @(negedge clk); tick = 1'b0;
    mptr = (mptr + 1) % 16;
    chk("R4 time_ptr step", time_ptr == 4'(mptr), int'(time_ptr), mptr);
  endtask

  initial begin
    #800000;
    fails++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [15:0] e;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R9 / R4 reset state
    chk("R4 reset ptr", time_ptr == 4'd0, int'(time_ptr), 0);
    chk("R9 reset rd_valid", rd_valid == 1'b0, int'(rd_valid), 0);
    chk("R9 reset bad_index", bad_index == 1'b0, int'(bad_index), 0);

    // Clear every slot through the read port (R5), stepping the ring (R4 wrap)
    for (int s = 0; s < 16; s++) begin
      for (int n = 0; n < N; n++) rd_raw(n);
      tick1();
    end
    for (int n = 0; n < N; n++) for (int s = 0; s < 16; s++) mdl[n][s] = '0;
    chk("R4 wrap to 0", time_ptr == 4'd0, int'(time_ptr), 0);

    // R1/R2 sweep: two words per neuron over many delays and weights
    for (int n = 0; n < N; n++) begin
      send(n % 16, n, 16'(n * 523 - 4000), 1'b0);
      send((n * 5 + 3) % 16, n, 16'(n * 97 + 11), 1'b0);
    end
    // R2 two's complement wrap
    send(2, 7, 16'h7000, 1'b0);
    send(2, 7, 16'h7000, 1'b0);
    // R1 reserved bit has no effect
    send(4, 9, 16'd11, 1'b1);
    // R6 out-of-range indices, including one aliasing neuron 5
    send(1, 40, 16'h0055, 1'b0);
    send(0, 2047, 16'h0123, 1'b0);
    send(3, 37, 16'h0200, 1'b0);

    for (int s = 0; s < 16; s++) begin
      for (int n = 0; n < N; n++) rd_chk(n, "R2 slot value");
      tick1();
    end

    // R5: second read of same slot is zero
    send(0, 1, 16'd321, 1'b0);
    rd_chk(1, "R5 first read");
    rd_chk(1, "R5 second read zero");

    // R8: three back-to-back words, read next cycle, word right after the read
    @(negedge clk); word_valid = 1'b1; word_data = mk(0, 3, 16'd100, 1'b0);
    @(posedge clk);
    @(negedge clk); word_data = mk(0, 3, 16'd20, 1'b0);
    @(posedge clk);
    @(negedge clk); word_data = mk(0, 3, 16'hFFFD, 1'b0);
    @(posedge clk);
    @(negedge clk); word_valid = 1'b0; rd_req = 1'b1; rd_neuron = 11'd3;
    @(posedge clk);
    @(negedge clk); rd_req = 1'b0; word_valid = 1'b1; word_data = mk(0, 3, 16'd55, 1'b0);
    @(posedge clk);
    @(negedge clk); word_valid = 1'b0;
    chk("R8 rd_valid", rd_valid == 1'b1, int'(rd_valid), 1);
    chk("R8 forwarded sum", rd_current == 16'd117, int'(rd_current), 117);
    mdl[3][mptr] = 16'd55;
    rd_chk(3, "R8 word after read");

    // R7: read and word together; read first, word next cycle
    send(0, 4, 16'd9, 1'b0);
    e = mdl[4][mptr];
    @(negedge clk); rd_req = 1'b1; rd_neuron = 11'd4;
    word_valid = 1'b1; word_data = mk(0, 4, 16'd100, 1'b0);
    #1 chk("R7 ready low", word_ready == 1'b0, int'(word_ready), 0);
    @(posedge clk);
    @(negedge clk); rd_req = 1'b0;
    #1 chk("R7 ready high", word_ready == 1'b1, int'(word_ready), 1);
    @(posedge clk);
    @(negedge clk); word_valid = 1'b0;
    chk("R7 read first", rd_current == e && rd_valid, int'(rd_current), int'(e));
    mdl[4][mptr] = 16'd100;
    rd_chk(4, "R7 held word accepted");

    // R4: word in the same cycle as tick uses old pointer
    @(negedge clk); tick = 1'b1; word_valid = 1'b1; word_data = mk(1, 6, 16'd7, 1'b0);
    @(posedge clk);
    @(negedge clk); tick = 1'b0; word_valid = 1'b0;
    madd(1, 6, 16'd7);
    mptr = (mptr + 1) % 16;
    rd_chk(6, "R4 tick collision slot");

    repeat (2) @(posedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule